// File: doc/BRIEF.md
# Accumulator processor with split instruction and data stores

A small multicycle processor built around one accumulator register. Program words and data words live in two separate internal arrays. A program counter and an instruction address register read the instruction array. A data address register and a data register carry traffic to and from the data array. The processor runs nine operations: load, add, subtract, store, read from an input port, write to an output port, an unconditional jump, a skip when the accumulator is zero, and a stop.

While reset is held, the surrounding logic writes both arrays through a preload port. After reset is released, execution starts at instruction address 0. It continues until a stop instruction is reached. The processor then holds a halted flag until the next reset. Values written by the output instruction appear on `out_data`, and `out_valid` is high for one cycle with each of them.

Each instruction takes a fetch phase of two cycles and a decode cycle. Operations on the data array add one cycle for a store, or two cycles for a load, add or subtract.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and just after it, `halted` and `out_valid` are 0 and `out_data` is 0. The first instruction executed after reset is the one at instruction address 0.
- R2: An instruction word is DW bits. Bits [AW-1:0] hold an address. Bits [DW-1:AW] hold the operation code, with this numbering: 1 load, 2 add, 3 store, 4 subtract, 5 input, 6 output, 7 stop, 8 jump, 9 skip-if-zero.
- R3: Load copies data word [addr] into the accumulator. Add and subtract combine the accumulator with data word [addr], wrapping modulo 2^DW in two's complement. Store writes the accumulator to data word [addr] and leaves the accumulator unchanged.
- R4: The input operation loads the accumulator from `in_data`. Each output operation drives the accumulator onto `out_data` and raises `out_valid` for exactly one cycle. `out_data` keeps that value until the next output operation or reset.
- R5: The jump operation continues execution at the instruction address given by its address field.
- R6: The skip-if-zero operation steps over the next instruction when the accumulator is zero. Otherwise execution continues with the next instruction.
- R7: The stop operation raises `halted`. `halted` stays high until reset, and after it no further output pulse appears and `out_data` does not change.
- R8: Operation codes 0 and 10 and above have no effect other than moving on to the next instruction.
- R9: A preload write with `ld_en` high while reset is high stores `ld_data` at `ld_addr`: into the instruction array when `ld_imem` is 1, into the data array when `ld_imem` is 0. With reset low, `ld_en` is ignored. Both arrays keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables preload |
| ld_en | input | 1 | Preload write strobe |
| ld_imem | input | 1 | Preload target: 1 instruction array, 0 data array |
| ld_addr | input | AW | Preload word address |
| ld_data | input | DW | Preload word |
| in_data | input | DW | Value taken by the input operation |
| out_data | output | DW | Value of the last output operation |
| out_valid | output | 1 | One-cycle strobe for each output operation |
| halted | output | 1 | High after a stop operation, until reset |

## Verification
The assertions assume that every program run by the bench reaches a stop instruction. They also assume that `in_data` is steady around the decode cycle of an input operation. The bench changes `in_data` only at falling edges, and it changes it only before a run starts or after `halted` has risen. Preload writes are issued only under reset. The one exception is a single deliberate write made with reset low, and its result is read back through a load followed by an output operation. Every program keeps its jump targets and data addresses inside the instruction and data words that were preloaded.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic          ld_imem,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted
);
  localparam int OPW   = DW - AW;
  localparam int DEPTH = 1 << AW;

  localparam logic [OPW-1:0] OP_LOAD  = OPW'(1);
  localparam logic [OPW-1:0] OP_ADD   = OPW'(2);
  localparam logic [OPW-1:0] OP_STORE = OPW'(3);
  localparam logic [OPW-1:0] OP_SUB   = OPW'(4);
  localparam logic [OPW-1:0] OP_IN    = OPW'(5);
  localparam logic [OPW-1:0] OP_OUT   = OPW'(6);
  localparam logic [OPW-1:0] OP_END   = OPW'(7);
  localparam logic [OPW-1:0] OP_JMP   = OPW'(8);
  localparam logic [OPW-1:0] OP_SKIPZ = OPW'(9);

  typedef enum logic [2:0] {S_F0, S_F1, S_DEC, S_DM, S_EX, S_HALT} state_t;

  logic [DW-1:0] imem [DEPTH];
  logic [DW-1:0] dmem [DEPTH];

  state_t        st;
  logic [AW-1:0] pc, imar, dmar;
  logic [DW-1:0] ir, dmdr, acc;

  wire [OPW-1:0] op    = ir[DW-1:AW];
  wire [AW-1:0]  fld   = ir[AW-1:0];
  wire           memop = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_STORE);

  assign halted = (st == S_HALT);

  always_ff @(posedge clk)
    if (rst && ld_en && ld_imem) imem[ld_addr] <= ld_data;

  always_ff @(posedge clk)
    if (rst) begin
      if (ld_en && !ld_imem) dmem[ld_addr] <= ld_data;
    end else if (st == S_DM && op == OP_STORE) begin
      dmem[dmar] <= dmdr;
    end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_F0;
      pc        <= '0;
      imar      <= '0;
      dmar      <= '0;
      ir        <= '0;
      dmdr      <= '0;
      acc       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        S_F0: begin
          imar <= pc;
          st   <= S_F1;
        end
        S_F1: begin
          ir <= imem[imar];
          pc <= pc + AW'(1);
          st <= S_DEC;
        end
        S_DEC: begin
          st <= S_F0;
          if (memop) begin
            dmar <= fld;
            if (op == OP_STORE) dmdr <= acc;
            st <= S_DM;
          end else begin
            case (op)
              OP_IN:    acc <= in_data;
              OP_OUT:   begin out_data <= acc; out_valid <= 1'b1; end
              OP_END:   st <= S_HALT;
              OP_JMP:   pc <= fld;
              OP_SKIPZ: if (acc == '0) pc <= pc + AW'(1);
              default:  ;
            endcase
          end
        end
        S_DM: begin
          if (op == OP_STORE) st <= S_F0;
          else begin
            dmdr <= dmem[dmar];
            st   <= S_EX;
          end
        end
        S_EX: begin
          case (op)
            OP_ADD:  acc <= acc + dmdr;
            OP_SUB:  acc <= acc - dmdr;
            default: acc <= dmdr;
          endcase
          st <= S_F0;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R4
  AST_OUT_ONLY_ON_OP: assert property (@(posedge clk) disable iff (rst)
    !(st == S_DEC && op == OP_OUT) |=> !out_valid); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !out_valid && $stable(out_data) && $stable(acc)); // R7
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && op == OP_JMP) |=> pc == $past(fld)); // R5
  AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && op == OP_SKIPZ && acc == '0) |=> pc == $past(pc) + AW'(1)); // R6
  AST_SKIP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && op == OP_SKIPZ && acc != '0) |=> $stable(pc)); // R6
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (st == S_DM && op == OP_STORE) |=> $stable(acc)); // R3
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_imem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0, in_data = '0;
  logic [DW-1:0] out_data;
  logic out_valid, halted;

  acc_cpu #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_imem(ld_imem), .ld_addr(ld_addr),
    .ld_data(ld_data), .in_data(in_data), .out_data(out_data),
    .out_valid(out_valid), .halted(halted));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  logic [DW-1:0] prog [16];
  int plen;
  logic [DW-1:0] outs [8];
  int nout;
  logic [DW-1:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  localparam logic [7:0] LOAD = 1, ADD = 2, STORE = 3, SUB = 4, IN = 5, OUT = 6, ENDOP = 7, JMP = 8, SKIPZ = 9;

  function automatic logic [DW-1:0] ins(input logic [7:0] o, input logic [7:0] a);
    return {o, a};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic im, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_imem = im; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input bit set_d, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < plen; i++) wr(1'b1, AW'(i), prog[i]);
    if (set_d) begin
      wr(1'b0, 8'd0, d0);
      wr(1'b0, 8'd1, d1);
    end
    @(negedge clk);
    rst = 1'b0;
    nout = 0;
    for (int c = 0; c < 600 && !halted; c++) begin
      @(negedge clk);
      if (out_valid && nout < 8) begin outs[nout] = out_data; nout++; end
    end
    chk("R7 halted after stop", {15'd0, halted}, 16'd1);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 halted in reset", {15'd0, halted}, 16'd0);
    chk("R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
    chk("R1 out_data in reset", out_data, 16'd0);

    // R2 R3 R4: arithmetic sweep with input, store and reload
    plen = 11;
    prog[0] = ins(IN, 0);    prog[1] = ins(STORE, 10); prog[2] = ins(LOAD, 0);
    prog[3] = ins(ADD, 1);   prog[4] = ins(OUT, 0);    prog[5] = ins(SUB, 1);
    prog[6] = ins(SUB, 1);   prog[7] = ins(OUT, 0);    prog[8] = ins(LOAD, 10);
    prog[9] = ins(OUT, 0);   prog[10] = ins(ENDOP, 0);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        in_data = vals[(i + j) % 6] ^ 16'h0F0F;
        run(1'b1, vals[i], vals[j]);
        chk("R4 output count", 16'(nout), 16'd3);
        chk("R3 add wraps", outs[0], vals[i] + vals[j]);
        chk("R3 subtract wraps", outs[1], vals[i] - vals[j]);
        chk("R3 R4 input stored and reloaded", outs[2], vals[(i + j) % 6] ^ 16'h0F0F);
      end

    // R7: nothing changes after halt
    in_data = 16'hBEEF;
    begin
      logic [DW-1:0] held;
      bit pulsed;
      held = out_data;
      pulsed = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (out_valid || !halted) pulsed = 1;
      end
      chk("R7 no pulse and still halted", {15'd0, pulsed}, 16'd0);
      chk("R7 out_data held", out_data, held);
    end

    // R1: reset clears outputs
    @(negedge clk); rst = 1'b1; @(negedge clk);
    chk("R1 out_data cleared by reset", out_data, 16'd0);
    chk("R1 halted cleared by reset", {15'd0, halted}, 16'd0);

    // R6: skip-if-zero over each sweep value
    plen = 6;
    prog[0] = ins(LOAD, 0); prog[1] = ins(SKIPZ, 0); prog[2] = ins(OUT, 0);
    prog[3] = ins(LOAD, 1); prog[4] = ins(OUT, 0);   prog[5] = ins(ENDOP, 0);
    for (int i = 0; i < 6; i++) begin
      run(1'b1, vals[i], 16'h5A5A);
      if (vals[i] == 0) begin
        chk("R6 zero skips", 16'(nout), 16'd1);
        chk("R6 zero skips value", outs[0], 16'h5A5A);
      end else begin
        chk("R6 nonzero falls through", 16'(nout), 16'd2);
        chk("R6 nonzero first value", outs[0], vals[i]);
        chk("R6 nonzero second value", outs[1], 16'h5A5A);
      end
    end

    // R5: jump forward and backward
    plen = 6;
    prog[0] = ins(JMP, 3);  prog[1] = ins(OUT, 0); prog[2] = ins(ENDOP, 0);
    prog[3] = ins(LOAD, 0); prog[4] = ins(OUT, 0); prog[5] = ins(JMP, 2);
    run(1'b1, 16'h3C3C, 16'h0);
    chk("R5 jumps skip output", 16'(nout), 16'd1);
    chk("R5 jumped path value", outs[0], 16'h3C3C);

    // R8: undefined opcodes act as no-ops
    plen = 6;
    prog[0] = ins(LOAD, 0); prog[1] = ins(8'd0, 8'd1); prog[2] = ins(8'd10, 8'd1);
    prog[3] = ins(8'hFF, 8'd0); prog[4] = ins(OUT, 0); prog[5] = ins(ENDOP, 0);
    run(1'b1, 16'h2468, 16'h1111);
    chk("R8 no-op count", 16'(nout), 16'd1);
    chk("R8 accumulator untouched", outs[0], 16'h2468);

    // R9: preload ignored with reset low; data kept through reset
    wr(1'b0, 8'd0, 16'hDEAD);
    plen = 3;
    prog[0] = ins(LOAD, 0); prog[1] = ins(OUT, 0); prog[2] = ins(ENDOP, 0);
    run(1'b0, 16'h0, 16'h0);
    chk("R9 write without reset ignored", outs[0], 16'h2468);
    run(1'b1, 16'h7777, 16'h0);
    chk("R9 write under reset lands", outs[0], 16'h7777);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule